// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous controller for a 128K x 8 asynchronous DRAM that takes a multiplexed address. The host side is a valid/ready request port. Each request carries a 17-bit byte address, a write flag and a data byte. The controller splits the address into row bits `addr[16:9]` and column bits `addr[8:0]`. It drives the row and column strobes, write enable and output enable, and it puts row or column onto the 9 address pins.

Once a row is open it stays open. A later request to the same row is served with a column strobe cycle alone, which is the fast page mode case. A request to another row first closes the row and waits out precharge. A refresh hold-off input from outside also closes the row, after the minimum strobe-low time, and keeps it closed for as long as it is high. If a page burst runs long, the row is also closed before the maximum row-strobe low time is reached. Every timing minimum is a parameter counted in clock cycles. The defaults are rounded up for a 10 ns clock.

The state machine has four states:
- `ST_IDLE`: row closed, precharging.
- `ST_ROWACT`: row strobe low, waiting out the row-to-column delay.
- `ST_COLACC`: column strobe low.
- `ST_PAGEOPEN`: row open, column strobe high.

It has six transitions:
- open: `ST_IDLE` to `ST_ROWACT`.
- rcd_done: `ST_ROWACT` to `ST_COLACC`.
- col_done: `ST_COLACC` to `ST_PAGEOPEN`, where read data is captured.
- page_hit: `ST_PAGEOPEN` to `ST_COLACC`.
- close: `ST_PAGEOPEN` to `ST_IDLE`, taken on a miss, on a hold-off or when the row limit is near.
- stay: any state to itself.

Top module: `fpd_dram_ctrl`

## Requirements
- R1: The row `addr[16:9]` is on `mem_a[7:0]` with `mem_a[8]`=0 when `mem_ras_n` falls. The column `addr[8:0]` is on `mem_a[8:0]` when `mem_cas_n` falls. Columns are issued in request order.
- R2: Each `mem_ras_n` low pulse lasts at least T_RAS_MIN and at most T_RAS_MAX cycles. A long burst to one row is broken by a close.
- R3: `mem_ras_n` stays high at least T_RP cycles. Falling edges of `mem_ras_n` are at least T_RC cycles apart. `mem_cas_n` has been high at least T_CRP cycles when `mem_ras_n` falls.
- R4: The first `mem_cas_n` fall after a `mem_ras_n` fall comes T_RCD to T_RCD_MAX (3) cycles later. The row stays on the pins for T_RAH cycles.
- R5: Each `mem_cas_n` low lasts at least T_CAS cycles. Inside a row, each high lasts at least T_CP cycles. Falling edges of `mem_cas_n` are at least T_PC cycles apart.
- R6: Read data is sampled only after `mem_cas_n` has been low for max(T_CAS,T_CAC,T_CAA) cycles and `mem_ras_n` has been low for T_RAC cycles. The byte is returned on a one-cycle `rd_valid` pulse, in request order.
- R7: For a write, `mem_we_n` is low and `mem_dq_oe` is high, with the data on `mem_dq_out`, from the cycle `mem_cas_n` falls. They stay that way for at least T_WDH cycles.
- R8: Back-to-back requests to the open row cause no new `mem_ras_n` fall.
- R9: A request to a different row raises `mem_ras_n` and then opens the new row with exactly one fall.
- R10: While `hold_req`=1, the open row is closed and no row is opened. `req_ready` stays 0 while the row is closed.
- R11: `mem_oe_n` is low only during read column cycles. `mem_dq_oe` is high only during write column cycles.
- R12: In reset, all strobes are high, `mem_dq_oe`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hold_req | input | 1 | Refresh hold-off: close row, open none |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address, row in [16:9] |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 8 | Read byte |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_a | output | 9 | Multiplexed address pins |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The bench's memory model returns inverted data until the access time has passed. A controller that samples one cycle too early therefore returns the wrong byte instead of slipping by unnoticed. Every strobe edge interval is measured against its minimum, so a short precharge, row-to-column delay or page cycle is reported at the edge where it occurs. A 120-access burst to one row, with the row limit shortened, catches a controller that never closes a row: it would hold the row strobe low past the maximum. Directed hit, miss and hold-off sequences catch extra or missing row cycles, and they catch a row opened while the hold-off is high.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ROWACT   = 2'd1,
        ST_COLACC   = 2'd2,
        ST_PAGEOPEN = 2'd3
    } fpd_state_e;
endpackage

// File: rtl/fpd_phase_ctr.sv
// Measures the current low and high phase of one strobe and keeps the
// length of the last completed low phase. Counts saturate at CNT_MAX.
module fpd_phase_ctr #(
    parameter int W       = 14,
    parameter int CNT_MAX = 7500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         low_nxt,
    output logic [W-1:0] low_cnt,
    output logic [W-1:0] high_cnt,
    output logic [W-1:0] last_low
);
    localparam logic [W-1:0] SAT = W'(CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
            last_low <= '0;
        end else if (low_nxt) begin
            if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
            high_cnt <= '0;
        end else begin
            if (low_cnt != '0) last_low <= low_cnt;
            low_cnt <= '0;
            if (high_cnt != SAT) high_cnt <= high_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fpd_addr_mux.sv
// Splits a byte address into row and column and selects which one the
// multiplexed pins carry.
module fpd_addr_mux #(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 9,
    parameter int PIN_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_col,
    output logic [PIN_W-1:0]  pins
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [PIN_W-1:0] row_pins;
    logic [PIN_W-1:0] col_pins;

    assign row = addr[ADDR_W-1:COL_W];
    assign col = addr[COL_W-1:0];

    generate
        if (PIN_W > ROW_W) begin : g_row_pad
            assign row_pins = {{(PIN_W-ROW_W){1'b0}}, row};
        end else begin : g_row_full
            assign row_pins = row;
        end
        if (PIN_W > COL_W) begin : g_col_pad
            assign col_pins = {{(PIN_W-COL_W){1'b0}}, col};
        end else begin : g_col_full
            assign col_pins = col;
        end
    endgenerate

    assign pins = sel_col ? col_pins : row_pins;
endmodule

// File: rtl/fpd_dram_ctrl.sv
module fpd_dram_ctrl
    import fpd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 8,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 7500,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RCD     = 2,
    parameter int T_RAH     = 1,
    parameter int T_CAS     = 1,
    parameter int T_CP      = 1,
    parameter int T_PC      = 3,
    parameter int T_CRP     = 1,
    parameter int T_RAC     = 5,
    parameter int T_CAC     = 2,
    parameter int T_CAA     = 3,
    parameter int T_WDH     = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   hold_req,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_we,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   mem_ras_n,
    output logic                                   mem_cas_n,
    output logic                                   mem_we_n,
    output logic                                   mem_oe_n,
    output logic [((ADDR_W-COL_W) > COL_W ? (ADDR_W-COL_W) : COL_W)-1:0] mem_a,
    output logic [DATA_W-1:0]                      mem_dq_out,
    output logic                                   mem_dq_oe,
    input  logic [DATA_W-1:0]                      mem_dq_in
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CW    = $clog2(T_RAS_MAX + 1) + 1;
    // Slack kept before the row limit: worst page wait plus worst column cycle.
    localparam int GUARD = T_PC + T_RAC + T_CAA + T_CAS + T_WDH + 2;
    localparam int DUE   = T_RAS_MAX - GUARD;
    localparam int RD_A  = (T_CAC > T_CAA) ? T_CAC : T_CAA;
    localparam int RD_MIN = (RD_A > T_CAS) ? RD_A : T_CAS;
    localparam int WR_MIN = (T_WDH > T_CAS) ? T_WDH : T_CAS;

    localparam logic [CW-1:0] C_RAS_MIN = CW'(T_RAS_MIN);
    localparam logic [CW-1:0] C_RAS_MAX = CW'(T_RAS_MAX);
    localparam logic [CW-1:0] C_DUE     = CW'(DUE);
    localparam logic [CW-1:0] C_RP      = CW'(T_RP);
    localparam logic [CW:0]   C_RC      = (CW+1)'(T_RC);
    localparam logic [CW-1:0] C_RCD     = CW'(T_RCD);
    localparam logic [CW-1:0] C_RAH     = CW'(T_RAH);
    localparam logic [CW-1:0] C_CP      = CW'(T_CP);
    localparam logic [CW:0]   C_PC      = (CW+1)'(T_PC);
    localparam logic [CW-1:0] C_CRP     = CW'(T_CRP);
    localparam logic [CW-1:0] C_RAC     = CW'(T_RAC);
    localparam logic [CW-1:0] C_RDMIN   = CW'(RD_MIN);
    localparam logic [CW-1:0] C_WRMIN   = CW'(WR_MIN);

    fpd_state_e state_q, state_d;

    logic              lat_we;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    logic [CW-1:0] ras_lo, ras_hi, ras_last;
    logic [CW-1:0] cas_lo, cas_hi, cas_last;

    logic accept, capture;
    logic row_hit, precharged, page_ready, close_due, ras_min_ok, col_done;
    logic want_close, sel_col;

    // One phase counter per strobe; next-state based so counts match the pins.
    fpd_phase_ctr #(.W(CW), .CNT_MAX(T_RAS_MAX)) u_ras_ph (
        .clk(clk), .rst_n(rst_n), .low_nxt(state_d != ST_IDLE),
        .low_cnt(ras_lo), .high_cnt(ras_hi), .last_low(ras_last)
    );

    fpd_phase_ctr #(.W(CW), .CNT_MAX(T_RAS_MAX)) u_cas_ph (
        .clk(clk), .rst_n(rst_n), .low_nxt(state_d == ST_COLACC),
        .low_cnt(cas_lo), .high_cnt(cas_hi), .last_low(cas_last)
    );

    fpd_addr_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
        .addr(lat_addr), .sel_col(sel_col), .pins(mem_a)
    );

    // Interlock conditions
    assign row_hit    = req_addr[ADDR_W-1:COL_W] == lat_addr[ADDR_W-1:COL_W];
    assign precharged = (ras_hi >= C_RP) && (cas_hi >= C_CRP) &&
                        (({1'b0, ras_last} + {1'b0, ras_hi}) >= C_RC);
    assign page_ready = (cas_hi >= C_CP) &&
                        (({1'b0, cas_last} + {1'b0, cas_hi}) >= C_PC);
    assign close_due  = ras_lo >= C_DUE;
    assign ras_min_ok = ras_lo >= C_RAS_MIN;
    assign col_done   = lat_we ? (cas_lo >= C_WRMIN)
                               : ((cas_lo >= C_RDMIN) && (ras_lo >= C_RAC));
    assign want_close = hold_req || close_due || (req_valid && !row_hit);

    always_comb begin
        unique case (state_q)
            ST_IDLE:     req_ready = !hold_req && precharged;
            ST_PAGEOPEN: req_ready = !want_close && row_hit && page_ready;
            default:     req_ready = 1'b0;
        endcase
    end
    assign accept = req_valid && req_ready;

    // Next-state process
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_ROWACT;                  // open
            end
            ST_ROWACT: begin
                if (ras_lo >= C_RCD) state_d = ST_COLACC;         // rcd_done
            end
            ST_COLACC: begin
                if (col_done) begin                                // col_done
                    capture = !lat_we;
                    state_d = ST_PAGEOPEN;
                end
            end
            ST_PAGEOPEN: begin
                if (want_close) begin
                    if (ras_min_ok) state_d = ST_IDLE;            // close
                end else if (accept) begin
                    state_d = ST_COLACC;                          // page_hit
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state_q  <= state_d;
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
            if (accept) begin
                lat_we    <= req_we;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
        end
    end

    // Output process (Moore, decoded from the registered state)
    always_comb begin
        mem_ras_n  = 1'b1;
        mem_cas_n  = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        sel_col    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROWACT: begin
                mem_ras_n = 1'b0;
                sel_col   = ras_lo > C_RAH;
            end
            ST_COLACC: begin
                mem_ras_n = 1'b0;
                mem_cas_n = 1'b0;
                mem_we_n  = !lat_we;
                mem_oe_n  = lat_we;
                mem_dq_oe = lat_we;
                sel_col   = 1'b1;
            end
            ST_PAGEOPEN: begin
                mem_ras_n = 1'b0;
                sel_col   = 1'b1;
            end
            default: ;
        endcase
    end
    assign mem_dq_out = lat_wdata;

    // Assertions
    p_ras_low_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n) |-> ras_last >= C_RAS_MIN);
    p_ras_low_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ras_n |-> ras_lo < C_RAS_MAX);
    p_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> $past(ras_hi) >= C_RP);
    p_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (!mem_ras_n && ras_lo > C_RCD));
    p_cas_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> $past(cas_hi) >= C_CP);
    p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cas_n));
    p_oe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cas_n && mem_we_n && !mem_dq_oe));
    p_hold_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && mem_ras_n) |=> mem_ras_n);
endmodule

// File: tb/sim_fpd_dram_ctrl.sv
module sim_fpd_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAS_MIN = 5;
    localparam int T_RAS_MAX = 200;
    localparam int T_RP = 3;
    localparam int T_RC = 9;
    localparam int T_RCD = 2;
    localparam int T_RCD_MAX = 3;
    localparam int T_RAH = 1;
    localparam int T_CAS = 1;
    localparam int T_CP = 1;
    localparam int T_PC = 3;
    localparam int T_CRP = 1;
    localparam int T_RAC = 5;
    localparam int T_CAC = 2;
    localparam int T_CAA = 3;
    localparam int T_WDH = 1;
    localparam int QN = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic rd_valid;
    logic [7:0] rd_data;
    logic mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [8:0] mem_a;
    logic [7:0] mem_dq_out;
    logic [7:0] mem_dq_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpd_dram_ctrl #(
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP), .T_RC(T_RC),
        .T_RCD(T_RCD), .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP), .T_PC(T_PC),
        .T_CRP(T_CRP), .T_RAC(T_RAC), .T_CAC(T_CAC), .T_CAA(T_CAA), .T_WDH(T_WDH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_a(mem_a), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference contents and DRAM model contents; index = {addr[11:9], addr[8:0]}
    logic [7:0] ref_mem [4096];
    logic [7:0] dram    [4096];
    logic        acc_we   [QN];
    logic [16:0] acc_addr [QN];
    logic [7:0]  exp_rd   [QN];
    int acc_wp = 0, acc_rp = 0, exp_wp = 0, exp_rp = 0;

    function automatic int idx_of(input logic [16:0] a);
        return int'({a[11:9], a[8:0]});
    endfunction

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 37 + 11);
    endfunction

    task automatic note_acc(input bit we, input logic [16:0] a, input logic [7:0] d);
        acc_we[acc_wp % QN] = we;
        acc_addr[acc_wp % QN] = a;
        acc_wp++;
        if (we) ref_mem[idx_of(a)] = d;
        else begin
            exp_rd[exp_wp % QN] = ref_mem[idx_of(a)];
            exp_wp++;
        end
    endtask

    task automatic do_req(input bit we, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        note_acc(we, a, d);
        #1 req_valid = 1'b0;
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    // DRAM model with edge-interval checks, sampled on the falling clock edge
    int ras_lo_n = 0, ras_hi_n = 0, last_ras_lo = 0;
    int cas_lo_n = 0, cas_hi_n = 0, last_cas_lo = 0;
    int n_ras_fall = 0, n_ras_rise = 0;
    bit first_cas = 1'b0, cur_we = 1'b0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    logic [7:0] row_l = '0;
    logic [8:0] col_l = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !mem_ras_n) begin
                chk(ras_hi_n >= T_RP, "R3 ras precharge", ras_hi_n, T_RP);
                chk(last_ras_lo + ras_hi_n >= T_RC, "R3 ras cycle", last_ras_lo + ras_hi_n, T_RC);
                chk(mem_cas_n && cas_hi_n >= T_CRP, "R3 cas high before ras", cas_hi_n, T_CRP);
                chk(mem_a[8] == 1'b0, "R1 row pin 8 low", int'(mem_a[8]), 0);
                row_l = mem_a[7:0];
                first_cas = 1'b1;
                ras_lo_n = 1;
                n_ras_fall++;
            end else if (!mem_ras_n) begin
                ras_lo_n++;
                if (ras_lo_n <= T_RAH)
                    chk(mem_a[7:0] == row_l, "R4 row hold", int'(mem_a), int'(row_l));
            end
            if (!p_ras && mem_ras_n) begin
                chk(ras_lo_n >= T_RAS_MIN && ras_lo_n <= T_RAS_MAX, "R2 ras low width",
                    ras_lo_n, T_RAS_MIN);
                last_ras_lo = ras_lo_n;
                ras_hi_n = 1;
                n_ras_rise++;
            end else if (mem_ras_n) begin
                ras_hi_n++;
            end

            if (p_cas && !mem_cas_n) begin
                chk(!mem_ras_n, "R5 cas inside row", int'(mem_ras_n), 0);
                if (first_cas)
                    chk(ras_lo_n - 1 >= T_RCD && ras_lo_n - 1 <= T_RCD_MAX,
                        "R4 ras to cas delay", ras_lo_n - 1, T_RCD);
                else begin
                    chk(cas_hi_n >= T_CP, "R5 cas precharge", cas_hi_n, T_CP);
                    chk(last_cas_lo + cas_hi_n >= T_PC, "R5 page cycle",
                        last_cas_lo + cas_hi_n, T_PC);
                end
                first_cas = 1'b0;
                col_l = mem_a;
                cur_we = !mem_we_n;
                cas_lo_n = 1;
                if (acc_rp == acc_wp) begin
                    chk(1'b0, "R1 column without request", int'(mem_a), 0);
                end else begin
                    chk({row_l, col_l} == acc_addr[acc_rp % QN], "R1 address split",
                        int'({row_l, col_l}), int'(acc_addr[acc_rp % QN]));
                    chk(cur_we == acc_we[acc_rp % QN], "R7 write enable at cas",
                        int'(cur_we), int'(acc_we[acc_rp % QN]));
                    acc_rp++;
                end
                if (cur_we) begin
                    chk(mem_dq_oe, "R7 data driven at cas", int'(mem_dq_oe), 1);
                    dram[int'({row_l[2:0], col_l})] = mem_dq_out;
                end
            end else if (!mem_cas_n) begin
                cas_lo_n++;
            end
            if (!p_cas && mem_cas_n) begin
                chk(cas_lo_n >= T_CAS, "R5 cas low width", cas_lo_n, T_CAS);
                if (cur_we) chk(cas_lo_n >= T_WDH, "R7 write hold", cas_lo_n, T_WDH);
                last_cas_lo = cas_lo_n;
                cas_hi_n = 1;
            end else if (mem_cas_n) begin
                cas_hi_n++;
            end

            if (!mem_oe_n) chk(!mem_cas_n && mem_we_n, "R11 oe only in read", int'(mem_we_n), 1);
            if (mem_dq_oe) chk(!mem_cas_n && !mem_we_n, "R11 bus only in write", int'(mem_we_n), 0);

            if (!mem_ras_n && !mem_cas_n && !cur_we) begin
                if (cas_lo_n >= T_CAC && cas_lo_n >= T_CAA && ras_lo_n >= T_RAC)
                    mem_dq_in = dram[int'({row_l[2:0], col_l})];
                else
                    mem_dq_in = ~dram[int'({row_l[2:0], col_l})];
            end else begin
                mem_dq_in = 8'hEE;
            end

            if (rd_valid) begin
                if (exp_rp == exp_wp) chk(1'b0, "R6 unexpected read data", int'(rd_data), 0);
                else begin
                    chk(rd_data == exp_rd[exp_rp % QN], "R6 read data",
                        int'(rd_data), int'(exp_rd[exp_rp % QN]));
                    exp_rp++;
                end
            end
        end else begin
            ras_hi_n++;
            cas_hi_n++;
        end
        p_ras = mem_ras_n;
        p_cas = mem_cas_n;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int f0, r0;
        bit seen;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) begin
            ref_mem[i] = init_byte(i);
            dram[i] = init_byte(i);
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R12 strobes high in reset",
            int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}), 15);
        chk(!mem_dq_oe && !rd_valid, "R12 bus and rd_valid low in reset",
            int'({mem_dq_oe, rd_valid}), 0);
        rst_n = 1'b1;

        // R1 boundary addresses and R8 page hit
        do_req(1'b1, {8'h00, 9'h000}, 8'h3C);
        do_req(1'b0, {8'h00, 9'h000}, 8'h00);
        quiet(12);
        f0 = n_ras_fall;
        do_req(1'b1, {8'h00, 9'h1FF}, 8'hA7);
        do_req(1'b0, {8'h00, 9'h1FF}, 8'h00);
        do_req(1'b0, {8'h00, 9'h055}, 8'h00);
        quiet(12);
        chk(n_ras_fall == f0, "R8 page hit keeps row open", n_ras_fall - f0, 0);

        // R9 row miss
        f0 = n_ras_fall; r0 = n_ras_rise;
        do_req(1'b0, {8'hFF, 9'h1FF}, 8'h00);
        quiet(12);
        chk(n_ras_rise == r0 + 1 && n_ras_fall == f0 + 1, "R9 miss closes and reopens",
            n_ras_fall - f0, 1);

        // R10 hold-off closes row and blocks requests
        @(negedge clk); hold_req = 1'b1;
        quiet(12);
        chk(mem_ras_n, "R10 row closed under hold", int'(mem_ras_n), 1);
        f0 = n_ras_fall;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = {8'h02, 9'h010}; req_wdata = 8'h5B;
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            #1; if (req_ready) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && n_ras_fall == f0, "R10 no accept or open under hold", int'(seen), 0);
        hold_req = 1'b0;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        note_acc(1'b1, {8'h02, 9'h010}, 8'h5B);
        #1 req_valid = 1'b0;
        do_req(1'b0, {8'h02, 9'h010}, 8'h00);

        // R2 long burst to one row must be broken by a close
        r0 = n_ras_rise;
        for (int k = 0; k < 120; k++)
            do_req(k[0], {8'h01, 9'(k * 5)}, 8'(k));
        quiet(12);
        chk(n_ras_rise > r0, "R2 long burst closes row", n_ras_rise - r0, 1);

        // Random mix over a few rows
        for (int k = 0; k < 400; k++) begin
            logic [2:0] rw;
            logic [8:0] cl;
            rw = 3'($urandom % 4);
            cl = 9'($urandom);
            do_req(1'($urandom), {5'b0, rw, cl}, 8'($urandom));
        end
        quiet(20);
        chk(exp_rp == exp_wp, "R6 all reads returned", exp_rp, exp_wp);
        chk(acc_rp == acc_wp, "R1 all requests issued", acc_rp, acc_wp);
        finish_run();
    end
endmodule